// File: doc/BRIEF.md
# Configuration and Status Register Bank

This block is a register bank that a processor reaches through a word-wide slave port with an address, a write enable, write data and read data. It holds two kinds of register. A raw register belongs to the core logic: the bank only forwards a bus write to the core together with a one-cycle strobe, and on a read it returns whatever the core is driving at that moment. A managed register is stored inside the bank. It is made of fields, and each field has one access rule for the bus side and another for the core side. Each rule is read-only, write-only or read-write.

A managed register wider than the bus word occupies several consecutive addresses. Its most significant word sits at the lowest of those addresses. A bus write to one of those words changes only the bits of that word. The register map is fixed at elaboration by parameters.

The default map has the following parts. The raw register is 12 bits wide at address 0. The managed register is 40 bits wide at addresses 1 to 3 and carries four fields:

| Field | Bits | Bus access | Core access |
|-------|------|------------|-------------|
| cfg | [7:0] | read-write | read-only |
| stat | [19:8] | read-only | write-only |
| cmd | [31:20] | write-only | read-only |
| shared | [39:32] | read-write | read-write |

Top module: `cfg_reg_bank`

## Requirements
- R1: A bus write to the raw address (0) makes `rawStrobe` high in the next cycle only, with `rawData` carrying bits [11:0] of the write data. `rawStrobe` is low in every cycle that does not follow such a write.
- R2: A bus read of the raw address returns `rawIn`, zero-extended to 16 bits, as sampled on the clock edge at which the address is presented. The bank keeps no copy of that value.
- R3: The 40-bit managed register is laid out as three bus words. Address 1 holds bits [39:32] in its low 8 bits, and its upper 8 bits read as zero. Address 2 holds bits [31:16]. Address 3 holds bits [15:0]. A write to one address changes only bits in that word.
- R4: The field layout and access rules are those in the table above. A core write-enable on a field that the core may only read has no effect.
- R5: `coreFieldOut` carries the stored value of every field the core may read (cfg, cmd, shared) at its own bit positions at all times. The bits of the stat field in `coreFieldOut` are zero.
- R6: When `coreFieldWe[f]` is high for a field the core may write (stat is index 1, shared is index 3), that field takes the matching bits of `coreFieldIn` at the next clock edge.
- R7: A bus write leaves the bits of the stat field unchanged, because the bus may only read that field.
- R8: A bus read returns zero in the bit positions of the cmd field, because the bus may only write that field.
- R9: When a bus write and a core write reach the same field in the same cycle, the field takes the core value.
- R10: `busRdata` is registered. It shows the addressed word one cycle after the address is presented. A read in the same cycle as a write to the same word returns the value from before that write.
- R11: Addresses 4 to 15 read as zero, and writes to them change nothing.
- R12: A synchronous active-high `rst` clears every stored field, `rawStrobe`, `rawData` and `busRdata` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| busAddr | input | 4 | Word address |
| busWe | input | 1 | Bus write enable |
| busWdata | input | 16 | Bus write data |
| busRdata | output | 16 | Registered bus read data |
| rawData | output | 12 | Data last written to the raw register |
| rawStrobe | output | 1 | One-cycle strobe marking rawData valid |
| rawIn | input | 12 | Core-driven value returned for raw reads |
| coreFieldOut | output | 40 | Stored fields visible to the core |
| coreFieldIn | input | 40 | Core write data for the fields |
| coreFieldWe | input | 4 | Per-field core write enable |

## Verification
Each result of this block is due exactly one clock edge after the stimulus that causes it:
- The read word for an address appears one edge after that address is presented.
- The raw strobe follows one edge after the raw write.
- A field written by the bus or the core shows on `coreFieldOut`, and on later reads, after one edge.

The bench applies inputs just after the falling edge and steps a behavioural model at the same rising edge as the design. It compares every output at the next falling edge, so each expected value lines up with the edge that produced it. Directed phases cover these cases:
- a read in the same cycle as a write;
- a bus write and a core write colliding on one field;
- writes to read-only bits;
- unmapped addresses;
- a reset applied mid-run.

A long pseudo-random phase then mixes all of these.

// File: rtl/cfg_reg_pkg.sv
package cfg_reg_pkg;

  typedef enum logic [1:0] {
    ACC_RO = 2'd0,
    ACC_WO = 2'd1,
    ACC_RW = 2'd2
  } access_e;

  // Width of the word index inside the managed register (up to 16 words).
  localparam int IDX_W = 4;

  // Strobes passed from address decode to the datapath.
  typedef struct packed {
    logic             rawWr;
    logic             rawRd;
    logic             mgdWr;
    logic             mgdRd;
    logic [IDX_W-1:0] wordIdx;
  } ctl_t;

  function automatic logic canRead(access_e a);
    return a != ACC_WO;
  endfunction

  function automatic logic canWrite(access_e a);
    return a != ACC_RO;
  endfunction

endpackage

// File: rtl/cfg_reg_ctrl.sv
module cfg_reg_ctrl
  import cfg_reg_pkg::*;
#(
  parameter int AW       = 4,
  parameter int RAW_ADDR = 0,
  parameter int MGD_BASE = 1,
  parameter int NW       = 3
) (
  input  logic [AW-1:0] busAddr,
  input  logic          busWe,
  output ctl_t          ctl
);

  localparam int MGD_LAST = MGD_BASE + NW - 1;

  logic          rawHit;
  logic          mgdHit;
  logic [AW-1:0] offset;

  always_comb begin
    rawHit = (busAddr == AW'(RAW_ADDR));
    mgdHit = (int'(busAddr) >= MGD_BASE) && (int'(busAddr) <= MGD_LAST);
    offset = busAddr - AW'(MGD_BASE);

    ctl.rawWr   = busWe & rawHit;
    ctl.rawRd   = rawHit;
    ctl.mgdWr   = busWe & mgdHit;
    ctl.mgdRd   = mgdHit;
    ctl.wordIdx = mgdHit ? IDX_W'(offset) : '0;
  end

endmodule

// File: rtl/cfg_reg_datapath.sv
module cfg_reg_datapath
  import cfg_reg_pkg::*;
#(
  parameter int      DW          = 16,
  parameter int      RAW_W       = 12,
  parameter int      MW          = 40,
  parameter int      NW          = 3,
  parameter int      NF          = 4,
  parameter int      FOFF  [NF]  = '{0, 8, 20, 32},
  parameter int      FWID  [NF]  = '{8, 12, 12, 8},
  parameter access_e FBUS  [NF]  = '{ACC_RW, ACC_RO, ACC_WO, ACC_RW},
  parameter access_e FCORE [NF]  = '{ACC_RO, ACC_WO, ACC_RO, ACC_RW}
) (
  input  logic             clk,
  input  logic             rst,
  input  ctl_t             ctl,
  input  logic [DW-1:0]    busWdata,
  output logic [DW-1:0]    busRdata,
  output logic [RAW_W-1:0] rawData,
  output logic             rawStrobe,
  input  logic [RAW_W-1:0] rawIn,
  output logic [MW-1:0]    coreFieldOut,
  input  logic [MW-1:0]    coreFieldIn,
  input  logic [NF-1:0]    coreFieldWe
);

  localparam int PW = NW * DW;

  // kind: 0 bus write, 1 bus read, 2 core read
  function automatic logic [MW-1:0] buildMask(input int kind);
    logic [MW-1:0] m;
    logic          ok;
    m = '0;
    for (int f = 0; f < NF; f++) begin
      case (kind)
        0:       ok = canWrite(FBUS[f]);
        1:       ok = canRead(FBUS[f]);
        default: ok = canRead(FCORE[f]);
      endcase
      for (int b = 0; b < MW; b++)
        if (ok && b >= FOFF[f] && b < FOFF[f] + FWID[f]) m[b] = 1'b1;
    end
    return m;
  endfunction

  localparam logic [MW-1:0] BUS_WR_MASK  = buildMask(0);
  localparam logic [MW-1:0] BUS_RD_MASK  = buildMask(1);
  localparam logic [MW-1:0] CORE_RD_MASK = buildMask(2);

  logic [MW-1:0]    fieldQ;
  logic [MW-1:0]    coreBitWe;
  logic [MW-1:0]    busBitWe;
  logic [MW-1:0]    wrBits;
  logic [PW-1:0]    padded;
  logic [DW-1:0]    rdWord;
  logic [DW-1:0]    rdQ;
  logic [RAW_W-1:0] rawDataQ;
  logic             rawStrobeQ;

  // Per-bit core write enables from the per-field enables.
  always_comb begin
    coreBitWe = '0;
    for (int f = 0; f < NF; f++)
      for (int b = 0; b < MW; b++)
        if (canWrite(FCORE[f]) && coreFieldWe[f] &&
            b >= FOFF[f] && b < FOFF[f] + FWID[f])
          coreBitWe[b] = 1'b1;
  end

  // Per-bit bus write enables: word 0 (lowest address) is the top word.
  always_comb begin
    for (int b = 0; b < MW; b++) begin
      busBitWe[b] = ctl.mgdWr && BUS_WR_MASK[b] &&
                    (ctl.wordIdx == IDX_W'(NW - 1 - b / DW));
      wrBits[b]   = busWdata[b % DW];
    end
  end

  // Field storage; the core side has priority over the bus side.
  always_ff @(posedge clk) begin
    if (rst) begin
      fieldQ <= '0;
    end else begin
      fieldQ <= (fieldQ & ~(coreBitWe | busBitWe))
              | (coreFieldIn & coreBitWe)
              | (wrBits & busBitWe & ~coreBitWe);
    end
  end

  // Read word selection.
  always_comb begin
    padded = PW'(fieldQ & BUS_RD_MASK);
    rdWord = '0;
    for (int k = 0; k < NW; k++)
      if (ctl.wordIdx == IDX_W'(k))
        rdWord = padded[(NW - 1 - k) * DW +: DW];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdQ        <= '0;
      rawDataQ   <= '0;
      rawStrobeQ <= 1'b0;
    end else begin
      if (ctl.rawRd)      rdQ <= DW'(rawIn);
      else if (ctl.mgdRd) rdQ <= rdWord;
      else                rdQ <= '0;
      rawStrobeQ <= ctl.rawWr;
      if (ctl.rawWr) rawDataQ <= busWdata[RAW_W-1:0];
    end
  end

  assign busRdata     = rdQ;
  assign rawData      = rawDataQ;
  assign rawStrobe    = rawStrobeQ;
  assign coreFieldOut = fieldQ & CORE_RD_MASK;

endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
  import cfg_reg_pkg::*;
#(
  parameter int      AW          = 4,
  parameter int      DW          = 16,
  parameter int      RAW_W       = 12,
  parameter int      RAW_ADDR    = 0,
  parameter int      MGD_BASE    = 1,
  parameter int      MW          = 40,
  parameter int      NF          = 4,
  parameter int      FOFF  [NF]  = '{0, 8, 20, 32},
  parameter int      FWID  [NF]  = '{8, 12, 12, 8},
  parameter access_e FBUS  [NF]  = '{ACC_RW, ACC_RO, ACC_WO, ACC_RW},
  parameter access_e FCORE [NF]  = '{ACC_RO, ACC_WO, ACC_RO, ACC_RW}
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    busAddr,
  input  logic             busWe,
  input  logic [DW-1:0]    busWdata,
  output logic [DW-1:0]    busRdata,
  output logic [RAW_W-1:0] rawData,
  output logic             rawStrobe,
  input  logic [RAW_W-1:0] rawIn,
  output logic [MW-1:0]    coreFieldOut,
  input  logic [MW-1:0]    coreFieldIn,
  input  logic [NF-1:0]    coreFieldWe
);

  localparam int NW = (MW + DW - 1) / DW;

  ctl_t ctl;

  cfg_reg_ctrl #(
    .AW(AW), .RAW_ADDR(RAW_ADDR), .MGD_BASE(MGD_BASE), .NW(NW)
  ) u_ctrl (
    .busAddr(busAddr),
    .busWe  (busWe),
    .ctl    (ctl)
  );

  cfg_reg_datapath #(
    .DW(DW), .RAW_W(RAW_W), .MW(MW), .NW(NW), .NF(NF),
    .FOFF(FOFF), .FWID(FWID), .FBUS(FBUS), .FCORE(FCORE)
  ) u_dp (
    .clk         (clk),
    .rst         (rst),
    .ctl         (ctl),
    .busWdata    (busWdata),
    .busRdata    (busRdata),
    .rawData     (rawData),
    .rawStrobe   (rawStrobe),
    .rawIn       (rawIn),
    .coreFieldOut(coreFieldOut),
    .coreFieldIn (coreFieldIn),
    .coreFieldWe (coreFieldWe)
  );

endmodule

// File: rtl/cfg_reg_bank_chk.sv
module cfg_reg_bank_chk
  import cfg_reg_pkg::*;
#(
  parameter int      AW          = 4,
  parameter int      DW          = 16,
  parameter int      RAW_W       = 12,
  parameter int      RAW_ADDR    = 0,
  parameter int      MGD_BASE    = 1,
  parameter int      MW          = 40,
  parameter int      NF          = 4,
  parameter int      FOFF  [NF]  = '{0, 8, 20, 32},
  parameter int      FWID  [NF]  = '{8, 12, 12, 8},
  parameter access_e FCORE [NF]  = '{ACC_RO, ACC_WO, ACC_RO, ACC_RW}
) (
  input logic             clk,
  input logic             rst,
  input logic [AW-1:0]    busAddr,
  input logic             busWe,
  input logic [DW-1:0]    busWdata,
  input logic [DW-1:0]    busRdata,
  input logic [RAW_W-1:0] rawData,
  input logic             rawStrobe,
  input logic [RAW_W-1:0] rawIn,
  input logic [MW-1:0]    coreFieldOut,
  input logic [MW-1:0]    coreFieldIn,
  input logic [NF-1:0]    coreFieldWe
);

  localparam int NW = (MW + DW - 1) / DW;

  logic rawSel;
  logic unmapped;

  assign rawSel   = (busAddr == AW'(RAW_ADDR));
  assign unmapped = !rawSel &&
                    !((int'(busAddr) >= MGD_BASE) && (int'(busAddr) < MGD_BASE + NW));

  // R1: a raw write yields a strobe with the written data on the next cycle.
  p_raw_strobe_r1: assert property (@(posedge clk) disable iff (rst)
    busWe && rawSel |=> rawStrobe && rawData == $past(busWdata[RAW_W-1:0]));

  // R1: the strobe only ever follows a raw write.
  p_strobe_cause_r1: assert property (@(posedge clk) disable iff (rst)
    rawStrobe |-> $past(busWe && rawSel));

  // R2: a raw read returns the core value sampled at the address edge.
  p_raw_read_r2: assert property (@(posedge clk) disable iff (rst)
    rawSel |=> busRdata == DW'($past(rawIn)));

  // R11: an unmapped address reads as zero.
  p_unmapped_r11: assert property (@(posedge clk) disable iff (rst)
    unmapped |=> busRdata == '0);

  // R12: outputs are clear right after reset.
  p_reset_clear_r12: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> busRdata == '0 && !rawStrobe && coreFieldOut == '0);

  // R6: a core write to a field the core can also read becomes visible one edge later.
  for (genvar f = 0; f < NF; f++) begin : g_core
    if (canRead(FCORE[f]) && canWrite(FCORE[f])) begin : g_rw
      p_core_write_r6: assert property (@(posedge clk) disable iff (rst)
        coreFieldWe[f] |=> coreFieldOut[FOFF[f] +: FWID[f]] ==
                           $past(coreFieldIn[FOFF[f] +: FWID[f]]));
    end
  end

endmodule

bind cfg_reg_bank cfg_reg_bank_chk #(
  .AW(AW), .DW(DW), .RAW_W(RAW_W), .RAW_ADDR(RAW_ADDR), .MGD_BASE(MGD_BASE),
  .MW(MW), .NF(NF), .FOFF(FOFF), .FWID(FWID), .FCORE(FCORE)
) u_chk (
  .clk(clk), .rst(rst), .busAddr(busAddr), .busWe(busWe), .busWdata(busWdata),
  .busRdata(busRdata), .rawData(rawData), .rawStrobe(rawStrobe), .rawIn(rawIn),
  .coreFieldOut(coreFieldOut), .coreFieldIn(coreFieldIn), .coreFieldWe(coreFieldWe)
);

// File: tb/sim_cfg_reg_bank.sv
`timescale 1ns/1ps
module sim_cfg_reg_bank;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic [11:0] rawData;
  logic        rawStrobe;
  logic [11:0] rawIn = '0;
  logic [39:0] coreFieldOut;
  logic [39:0] coreFieldIn = '0;
  logic [3:0]  coreFieldWe = '0;

  always #2.5 clk = ~clk;

  cfg_reg_bank u0 (
    .clk(clk), .rst(rst), .busAddr(busAddr), .busWe(busWe), .busWdata(busWdata),
    .busRdata(busRdata), .rawData(rawData), .rawStrobe(rawStrobe), .rawIn(rawIn),
    .coreFieldOut(coreFieldOut), .coreFieldIn(coreFieldIn), .coreFieldWe(coreFieldWe)
  );

  // Access masks taken from the field table (R4, R7, R8, R5).
  localparam logic [39:0] BUS_WR  = 40'hFF_FFF0_00FF; // cfg, cmd, shared
  localparam logic [39:0] BUS_RD  = 40'hFF_000F_FFFF; // cfg, stat, shared
  localparam logic [39:0] CORE_RD = 40'hFF_FFF0_00FF; // cfg, cmd, shared

  int    total = 0;
  int    bad   = 0;
  string curTag = "R12";
  bit    armed = 1'b0;

  // Behavioural reference model.
  logic [39:0] mMgd;
  logic [15:0] mRd;
  logic        mStrobe;
  logic [11:0] mRaw;
  logic [39:0] nxt;
  logic [47:0] pad;
  int          sh;

  always @(posedge clk) begin
    armed <= 1'b1;
    if (rst) begin
      mMgd <= '0; mRd <= '0; mStrobe <= 1'b0; mRaw <= '0;
    end else begin
      pad = {8'h00, mMgd & BUS_RD};
      case (busAddr)
        4'd0:    mRd <= {4'h0, rawIn};
        4'd1:    mRd <= pad[47:32];
        4'd2:    mRd <= pad[31:16];
        4'd3:    mRd <= pad[15:0];
        default: mRd <= '0;
      endcase
      mStrobe <= busWe && busAddr == 4'd0;
      if (busWe && busAddr == 4'd0) mRaw <= busWdata[11:0];
      nxt = mMgd;
      if (busWe && busAddr >= 4'd1 && busAddr <= 4'd3) begin
        sh = (3 - int'(busAddr)) * 16;
        for (int i = 0; i < 16; i++)
          if (sh + i < 40 && BUS_WR[sh + i]) nxt[sh + i] = busWdata[i];
      end
      if (coreFieldWe[1]) nxt[19:8]  = coreFieldIn[19:8];
      if (coreFieldWe[3]) nxt[39:32] = coreFieldIn[39:32];
      mMgd <= nxt;
    end
  end

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Compare every cycle away from the rising edge.
  always @(negedge clk) begin
    if (armed) begin
      chk(curTag, "busRdata", 64'(busRdata), 64'(mRd));
      chk((curTag == "R12") ? "R12" : "R1", "rawStrobe", 64'(rawStrobe), 64'(mStrobe));
      if (mStrobe) chk("R1", "rawData", 64'(rawData), 64'(mRaw));
      chk((curTag == "R12") ? "R12" : "R5", "coreFieldOut",
          64'(coreFieldOut), 64'(mMgd & CORE_RD));
    end
  end

  task automatic drive(input logic [3:0] a, input logic w, input logic [15:0] d,
                       input logic [3:0] ce, input logic [39:0] ci);
    @(negedge clk); #0.5;
    busAddr = a; busWe = w; busWdata = d; coreFieldWe = ce; coreFieldIn = ci;
  endtask

  task automatic rd(input logic [3:0] a);
    drive(a, 1'b0, 16'h0, 4'h0, coreFieldIn);
  endtask

  logic [31:0] lfsr = 32'h1ACE_B00C;
  function automatic logic [31:0] stepLfsr(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk); #0.5; rst = 1'b0;
    // R12: explicit reset-state checks.
    @(negedge clk);
    chk("R12", "reset busRdata", 64'(busRdata), 64'h0);
    chk("R12", "reset coreFieldOut", 64'(coreFieldOut), 64'h0);
    chk("R12", "reset rawStrobe", 64'(rawStrobe), 64'h0);

    curTag = "R1";
    drive(4'd0, 1'b1, 16'hFABC, 4'h0, '0);
    rd(4'd5); rd(4'd5);
    drive(4'd0, 1'b1, 16'h0123, 4'h0, '0);
    drive(4'd0, 1'b1, 16'h0456, 4'h0, '0);
    rd(4'd5);

    curTag = "R2";
    rawIn = 12'h5A5; rd(4'd0);
    rawIn = 12'h0F0; rd(4'd0);
    rawIn = 12'hFFF; rd(4'd0); rd(4'd6);

    curTag = "R7";
    drive(4'd1, 1'b1, 16'hFFA5, 4'h0, '0);
    drive(4'd2, 1'b1, 16'hFFFF, 4'h0, '0);
    drive(4'd3, 1'b1, 16'hFFFF, 4'h0, '0);
    curTag = "R8";
    rd(4'd1); rd(4'd2); rd(4'd3); rd(4'd5);

    curTag = "R6";
    drive(4'd5, 1'b0, 16'h0, 4'hF, 40'hC3_9876_5432);
    curTag = "R4";
    rd(4'd1); rd(4'd2); rd(4'd3);

    curTag = "R9";
    drive(4'd1, 1'b1, 16'h0011, 4'h8, 40'h7E_0000_0000);
    rd(4'd1); rd(4'd1);

    curTag = "R10";
    drive(4'd3, 1'b1, 16'h1234, 4'h0, '0);
    rd(4'd3);
    drive(4'd2, 1'b1, 16'hABCD, 4'h0, '0);
    rd(4'd2); rd(4'd5);

    curTag = "R11";
    drive(4'd7, 1'b1, 16'hFFFF, 4'h0, '0);
    drive(4'd15, 1'b1, 16'hFFFF, 4'h0, '0);
    rd(4'd7); rd(4'd15); rd(4'd1); rd(4'd2); rd(4'd3); rd(4'd5);

    curTag = "R3";
    for (int n = 0; n < 3000; n++) begin
      logic [3:0]  a;
      logic [3:0]  ce;
      lfsr = stepLfsr(lfsr);
      a  = (lfsr[3:0] > 4'd9) ? {2'b00, lfsr[5:4]} : lfsr[3:0];
      ce = (lfsr[12:10] == 3'd0) ? lfsr[19:16] : 4'h0;
      rawIn = lfsr[31:20];
      drive(a, lfsr[6], lfsr[31:16] ^ lfsr[15:0], ce,
            {lfsr[7:0], lfsr[31:0] ^ 32'h5A5A_C3C3});
    end

    curTag = "R12";
    drive(4'd0, 1'b1, 16'h0FFF, 4'h0, '0);
    @(negedge clk); #0.5; rst = 1'b1; busWe = 1'b0;
    @(negedge clk); #0.5; rst = 1'b0;
    @(negedge clk);
    chk("R12", "mid-run reset coreFieldOut", 64'(coreFieldOut), 64'h0);
    chk("R12", "mid-run reset rawStrobe", 64'(rawStrobe), 64'h0);
    rd(4'd1); rd(4'd3); rd(4'd5);

    @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule